// File: doc/BRIEF.md
# Key Poller with Standalone Volume Fallback

This block sits between four front-panel push buttons and the rest of an audio device. Each button is synchronised and debounced, and the block forms a small bitmap of the keys held down. It hands that bitmap over only when a host request arrives. It keeps two latched toggles, one for mute and one for bass boost. It also drives four general-purpose output pins from a simple write port.

When the serial bus is detached, the buttons still control the local volume logic directly. The volume keys produce one-cycle step commands and the mute key keeps toggling mute. Bass boost is forced off, and its key has no effect. The block also derives a suspend indication from the host's low-power request and from the attach state, and it blocks suspend while an analog source is present. Every frame-start strobe produces a one-cycle frame pulse, and the spacing between frame starts is checked against a nominal period.

Top module: `hid_key_ctrl`

## Requirements
- R1: A raw key level registers only after it has held steady for DEB_CYC clock cycles past a two-flop synchroniser. A pulse shorter than that leaves the debounced state and every output unchanged.
- R2: One cycle after report_req is high, report_valid is high for exactly one cycle. In that cycle report_keys carries the debounced keys with one-hot codes: bit0 (code 1) volume up, bit1 (code 2) volume down, bit2 (code 4) mute toggle, bit3 (code 8) bass-boost toggle. Without a request, report_valid stays low.
- R3: Each debounced press of key bit2 inverts mute_state, whether the bus is attached or not. A release has no effect.
- R4: A debounced press of key bit3 while attached is high inverts the stored bass-boost state. The bboost_en output equals the stored state while attached and is 0 while detached. Presses of key bit3 while detached do not change the stored state.
- R5: While attached is low, a debounced press of key bit0 or key bit1 yields exactly one single-cycle pulse on vol_up_step or vol_dn_step respectively. While attached is high, these outputs stay low.
- R6: gpo takes the value of gpo_wdata on the clock edge where gpo_we is high, and holds it otherwise.
- R7: suspend is the registered value of (suspend_req OR NOT attached) AND NOT aux_present. High means low power.
- R8: sof_pulse is high for exactly the one cycle that follows each cycle in which sof_strobe is high.
- R9: sof_gap_err is high together with sof_pulse when the number of cycles since the previous strobe lies outside FRAME_CYC ± FRAME_TOL. It is never raised for the first strobe after reset.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 4 | Raw key levels: bit0 vol up, bit1 vol down, bit2 mute, bit3 bass boost |
| attached | input | 1 | Bus attached and configured |
| report_req | input | 1 | Host asks for the current key report |
| report_valid | output | 1 | Report handed over this cycle |
| report_keys | output | 4 | One-hot key bitmap of the report |
| gpo_we | input | 1 | Write strobe for the general outputs |
| gpo_wdata | input | 4 | Value to write to the general outputs |
| gpo | output | 4 | General-purpose output pins |
| mute_state | output | 1 | Latched mute toggle |
| bboost_en | output | 1 | Bass boost enable (forced off when detached) |
| vol_up_step | output | 1 | Local volume-up step command |
| vol_dn_step | output | 1 | Local volume-down step command |
| suspend_req | input | 1 | Host requests low-power mode |
| aux_present | input | 1 | Analog source connected; blocks suspend |
| suspend | output | 1 | Low-power indication |
| sof_strobe | input | 1 | Frame-start strobe from the bus engine |
| sof_pulse | output | 1 | One-cycle frame pulse |
| sof_gap_err | output | 1 | Frame spacing outside tolerance |

## Verification
The bench sends a glitch a few cycles shorter than the debounce window on the mute key. A design that skipped the debounce count would toggle mute on that glitch. Random press sequences with random attach state check that bass-boost presses made while detached leave the stored toggle untouched. A design that only masked the output would show a different state after reattaching. The same sequences check that volume steps appear only while detached and exactly once per press. A design that stepped on level instead of edge, or stepped while attached, would fail the step counts. Frame strobes are spaced at exactly the tolerance limits and one cycle beyond them, both short and long. This exposes off-by-one interval counting and a spurious error on the first strobe after reset.

// File: rtl/hkc_pkg.sv
package hkc_pkg;
    localparam int NUM_KEYS = 4;
    localparam int NUM_GPO  = 4;

    // Key slot positions; the report code of a key is 1 << slot.
    localparam int K_VUP   = 0;
    localparam int K_VDN   = 1;
    localparam int K_MUTE  = 2;
    localparam int K_BOOST = 3;

    typedef logic [NUM_KEYS-1:0] key_vec_t;
    typedef logic [NUM_GPO-1:0]  gpo_vec_t;

    typedef struct packed {
        logic up;
        logic dn;
    } vol_cmd_t;

    typedef struct packed {
        logic mute;
        logic boost;
    } toggle_t;

    function automatic logic suspend_next(input logic req, input logic att,
                                          input logic aux);
        return (req | ~att) & ~aux;
    endfunction
endpackage

// File: rtl/hkc_debounce.sv
module hkc_debounce #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            level <= 1'b0;
            cnt   <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 != level) begin
                if (cnt == CW'(DEB_CYC - 1)) begin
                    level <= s2;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/hkc_frame_mon.sv
module hkc_frame_mon #(
    parameter int FRAME_CYC = 12000,
    parameter int FRAME_TOL = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic pulse,
    output logic gap_err
);
    localparam int GAP_MIN = FRAME_CYC - FRAME_TOL;
    localparam int GAP_MAX = FRAME_CYC + FRAME_TOL;
    localparam int GW      = $clog2(GAP_MAX + 2);

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            seen    <= 1'b0;
            pulse   <= 1'b0;
            gap_err <= 1'b0;
        end else begin
            pulse   <= strobe;
            gap_err <= 1'b0;
            if (strobe) begin
                gap_err <= seen && ((gap < GW'(GAP_MIN)) || (gap > GW'(GAP_MAX)));
                seen    <= 1'b1;
                gap     <= GW'(1);
            end else if (gap != GW'(GAP_MAX + 1)) begin
                gap <= gap + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hid_key_ctrl.sv
module hid_key_ctrl
    import hkc_pkg::*;
#(
    parameter int DEB_CYC   = 16,
    parameter int FRAME_CYC = 12000,
    parameter int FRAME_TOL = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] key_in,
    input  logic       attached,
    input  logic       report_req,
    output logic       report_valid,
    output logic [3:0] report_keys,
    input  logic       gpo_we,
    input  logic [3:0] gpo_wdata,
    output logic [3:0] gpo,
    output logic       mute_state,
    output logic       bboost_en,
    output logic       vol_up_step,
    output logic       vol_dn_step,
    input  logic       suspend_req,
    input  logic       aux_present,
    output logic       suspend,
    input  logic       sof_strobe,
    output logic       sof_pulse,
    output logic       sof_gap_err
);
    key_vec_t deb, deb_d, press;
    toggle_t  tog;
    vol_cmd_t vcmd;
    gpo_vec_t gpo_q;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        hkc_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk  (clk),
            .rst  (rst),
            .raw  (key_in[k]),
            .level(deb[k])
        );
    end

    assign press = deb & ~deb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            deb_d        <= '0;
            tog          <= '0;
            vcmd         <= '0;
            gpo_q        <= '0;
            report_valid <= 1'b0;
            report_keys  <= '0;
            suspend      <= 1'b0;
        end else begin
            deb_d <= deb;
            if (press[K_MUTE])
                tog.mute <= ~tog.mute;
            if (press[K_BOOST] && attached)
                tog.boost <= ~tog.boost;
            vcmd.up <= press[K_VUP] & ~attached;
            vcmd.dn <= press[K_VDN] & ~attached;
            if (gpo_we)
                gpo_q <= gpo_wdata;
            report_valid <= report_req;
            if (report_req)
                report_keys <= deb;
            suspend <= suspend_next(suspend_req, attached, aux_present);
        end
    end

    assign mute_state  = tog.mute;
    assign bboost_en   = tog.boost & attached;
    assign vol_up_step = vcmd.up;
    assign vol_dn_step = vcmd.dn;
    assign gpo         = gpo_q;

    hkc_frame_mon #(.FRAME_CYC(FRAME_CYC), .FRAME_TOL(FRAME_TOL)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .strobe (sof_strobe),
        .pulse  (sof_pulse),
        .gap_err(sof_gap_err)
    );
endmodule

// File: rtl/hid_key_ctrl_chk.sv
module hid_key_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       attached,
    input logic       report_req,
    input logic       report_valid,
    input logic       gpo_we,
    input logic [3:0] gpo,
    input logic       vol_up_step,
    input logic       vol_dn_step,
    input logic       aux_present,
    input logic       suspend,
    input logic       sof_strobe,
    input logic       sof_pulse,
    input logic       sof_gap_err
);
    a_r5_no_step_when_attached: assert property (@(posedge clk) disable iff (rst)
        (vol_up_step || vol_dn_step) |-> !$past(attached));

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        report_valid |-> $past(report_req));

    a_r6_gpo_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(gpo_we) |-> $stable(gpo));

    a_r7_aux_blocks_suspend: assert property (@(posedge clk) disable iff (rst)
        suspend |-> !$past(aux_present));

    a_r8_pulse_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> $past(sof_strobe));

    a_r9_err_with_pulse: assert property (@(posedge clk) disable iff (rst)
        sof_gap_err |-> sof_pulse);
endmodule

bind hid_key_ctrl hid_key_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .attached    (attached),
    .report_req  (report_req),
    .report_valid(report_valid),
    .gpo_we      (gpo_we),
    .gpo         (gpo),
    .vol_up_step (vol_up_step),
    .vol_dn_step (vol_dn_step),
    .aux_present (aux_present),
    .suspend     (suspend),
    .sof_strobe  (sof_strobe),
    .sof_pulse   (sof_pulse),
    .sof_gap_err (sof_gap_err)
);

// File: tb/hid_key_ctrl_test.sv
module hid_key_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEB       = 8;
    localparam int FCYC      = 100;
    localparam int FTOL      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] key_in = '0;
    logic       attached = 1'b0;
    logic       report_req = 1'b0;
    logic       report_valid;
    logic [3:0] report_keys;
    logic       gpo_we = 1'b0;
    logic [3:0] gpo_wdata = '0;
    logic [3:0] gpo;
    logic       mute_state, bboost_en, vol_up_step, vol_dn_step;
    logic       suspend_req = 1'b0;
    logic       aux_present = 1'b0;
    logic       suspend;
    logic       sof_strobe = 1'b0;
    logic       sof_pulse, sof_gap_err;

    int checks = 0;
    int errors = 0;
    int n_up = 0;
    int n_dn = 0;
    logic m_mute = 1'b0;
    logic m_boost = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hid_key_ctrl #(.DEB_CYC(DEB), .FRAME_CYC(FCYC), .FRAME_TOL(FTOL)) uut (
        .clk(clk), .rst(rst), .key_in(key_in), .attached(attached),
        .report_req(report_req), .report_valid(report_valid),
        .report_keys(report_keys), .gpo_we(gpo_we), .gpo_wdata(gpo_wdata),
        .gpo(gpo), .mute_state(mute_state), .bboost_en(bboost_en),
        .vol_up_step(vol_up_step), .vol_dn_step(vol_dn_step),
        .suspend_req(suspend_req), .aux_present(aux_present),
        .suspend(suspend), .sof_strobe(sof_strobe), .sof_pulse(sof_pulse),
        .sof_gap_err(sof_gap_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (vol_up_step) n_up++;
            if (vol_dn_step) n_dn++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_suspend(input logic r, input logic a, input logic x);
        return (r | ~a) & ~x;
    endfunction

    task automatic press(input int k);
        key_in[k] = 1'b1;
        repeat (DEB + 6) @(negedge clk);
        key_in[k] = 1'b0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    task automatic sof_after(input int n);
        repeat (n - 1) @(negedge clk);
        sof_strobe = 1'b1;
        @(negedge clk);
        sof_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset values
        chk({report_valid, report_keys, gpo, mute_state, bboost_en, vol_up_step,
             vol_dn_step, suspend, sof_pulse, sof_gap_err} == '0,
            "R10 reset outputs", int'(gpo), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: short glitch on the mute key is ignored
        key_in[2] = 1'b1;
        repeat (DEB - 3) @(negedge clk);
        key_in[2] = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        chk(mute_state == m_mute, "R1 glitch ignored", mute_state, m_mute);

        // R3: mute toggles while detached
        press(2); m_mute = ~m_mute;
        chk(mute_state == m_mute, "R3 mute toggle detached", mute_state, m_mute);

        // R5: detached volume steps
        press(0); n_up = n_up;
        chk(n_up == 1, "R5 vol up step", n_up, 1);
        press(1);
        chk(n_dn == 1, "R5 vol down step", n_dn, 1);

        // R4: bass press while detached has no effect
        press(3);
        chk(bboost_en == 1'b0, "R4 boost off detached", bboost_en, 0);
        attached = 1'b1;
        @(negedge clk);
        chk(bboost_en == m_boost, "R4 stored boost untouched", bboost_en, m_boost);
        press(3); m_boost = ~m_boost;
        chk(bboost_en == m_boost, "R4 boost toggle attached", bboost_en, m_boost);

        // R2: report with keys 0 and 3 held while attached
        key_in = 4'b1001;
        repeat (DEB + 6) @(negedge clk);
        m_boost = ~m_boost;
        chk(report_valid == 1'b0, "R2 no valid without request", report_valid, 0);
        report_req = 1'b1;
        @(negedge clk);
        report_req = 1'b0;
        chk(report_valid == 1'b1, "R2 valid after request", report_valid, 1);
        chk(report_keys == 4'b1001, "R2 one-hot key codes", report_keys, 9);
        @(negedge clk);
        chk(report_valid == 1'b0, "R2 valid single cycle", report_valid, 0);
        key_in = 4'b0000;
        repeat (DEB + 6) @(negedge clk);
        chk(n_up == 1, "R5 no step while attached", n_up, 1);

        // Random press mix with random attach state
        for (int i = 0; i < 24; i++) begin
            int k;
            k = int'($urandom % 4);
            attached = 1'($urandom % 2);
            @(negedge clk);
            press(k);
            if (k == 2) m_mute = ~m_mute;
            if (k == 3 && attached) m_boost = ~m_boost;
            if (k == 0 && !attached) n_up = n_up; // monitor counts; model below
            chk(mute_state == m_mute, "R3 random mute", mute_state, m_mute);
            chk(bboost_en == (m_boost & attached), "R4 random boost",
                bboost_en, int'(m_boost & attached));
        end
        begin
            int up0, dn0;
            up0 = n_up; dn0 = n_dn;
            attached = 1'b0;
            @(negedge clk);
            press(0); press(0); press(1);
            chk(n_up == up0 + 2, "R5 two up steps", n_up, up0 + 2);
            chk(n_dn == dn0 + 1, "R5 one down step", n_dn, dn0 + 1);
        end

        // R6: general outputs
        gpo_wdata = 4'hA; gpo_we = 1'b1;
        @(negedge clk);
        gpo_we = 1'b0; gpo_wdata = 4'h5;
        chk(gpo == 4'hA, "R6 gpo write", gpo, 10);
        repeat (3) @(negedge clk);
        chk(gpo == 4'hA, "R6 gpo hold", gpo, 10);

        // R7: suspend over all input combinations
        for (int c = 0; c < 8; c++) begin
            suspend_req = c[0]; attached = c[1]; aux_present = c[2];
            repeat (2) @(negedge clk);
            chk(suspend == exp_suspend(c[0], c[1], c[2]), "R7 suspend",
                suspend, exp_suspend(c[0], c[1], c[2]));
        end

        // R8/R9: frame strobes
        sof_after(10);
        chk(sof_pulse == 1'b1, "R8 pulse on strobe", sof_pulse, 1);
        chk(sof_gap_err == 1'b0, "R9 no error on first strobe", sof_gap_err, 0);
        @(negedge clk);
        chk(sof_pulse == 1'b0, "R8 pulse one cycle", sof_pulse, 0);
        sof_after(FCYC - 1);
        chk(sof_gap_err == 1'b0, "R9 nominal gap", sof_gap_err, 0);
        sof_after(FCYC + FTOL);
        chk(sof_gap_err == 1'b0, "R9 long limit", sof_gap_err, 0);
        sof_after(FCYC + FTOL + 1);
        chk(sof_gap_err == 1'b1, "R9 too long", sof_gap_err, 1);
        sof_after(FCYC - FTOL);
        chk(sof_gap_err == 1'b0, "R9 short limit", sof_gap_err, 0);
        sof_after(FCYC - FTOL - 1);
        chk(sof_gap_err == 1'b1, "R9 too short", sof_gap_err, 1);
        @(negedge clk);
        chk(sof_gap_err == 1'b0, "R9 error one cycle", sof_gap_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule